// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Delivery Controller

This block sits behind the source-mode logic of a wired interrupt controller and handles the hart-facing side of it. Each source has a target record here. The record names the hart that should take the source and gives the source's priority. Each hart has three control bits or fields of its own: a delivery enable, a force bit and a priority threshold. The source-mode logic keeps the per-source enable and pending bits and the raw input levels, and it presents them as vectors. Each hart has its own selector. The selector picks the most urgent source that is enabled, pending and aimed at that hart, registers the result as a top-interrupt word, and drives the hart's external interrupt line from it.

Software reaches the block through a simple word-wide register port. Reads of the claim location return the registered top-interrupt word. In the same cycle, such a read pulses a clear-pending strobe back to the source logic for the claimed source. The strobe is not raised when the source is level-sensitive and its input is still at the active level, so that source stays pending. A claim that finds nothing to take drops the hart's force bit.

Top module: `hart_irq_deliver`

## Requirements
- R1: After reset every delivery bit, force bit and threshold is 0, every target record holds hart 0 with priority 1, every top-interrupt word reads 0 and every interrupt line is low.
- R2: A source is a candidate for hart h only when its enable and pending inputs are both 1 and its stored target hart equals h; a target hart with no existing window selects no hart.
- R3: Among candidates the smallest priority number wins; on equal priority the smaller source number wins.
- R4: A threshold of 0 lets every candidate through; a nonzero threshold admits only candidates whose priority is strictly less than it.
- R5: The top-interrupt word carries the winning source number in bits 25:16 and its priority in bits 7:0, reads 0 when there is no candidate, and reflects the inputs and registers as they were one clock earlier.
- R6: A hart's line is high exactly when the domain enable input is 1, the hart's delivery bit is 1 and either its force bit is 1 or its top-interrupt word is nonzero.
- R7: A claim read returns the top-interrupt word and, in the same cycle, pulses pend_clr_o for the returned source, except when that source is level-high with raw input 1 or level-low with raw input 0, in which case no pulse is raised.
- R8: A claim read that returns 0 clears that hart's force bit.
- R9: Hart h's window starts at byte address 0x100 + 32*h, with delivery at offset 0x00, force at 0x04, threshold at 0x08, top interrupt at 0x18 and claim at 0x1C. Delivery and force keep only bit 0, the threshold keeps only the low PW bits, and other offsets or harts beyond NHART read 0.
- R10: The target record of source s (1..NSRC) is at byte address 4*s, with the hart in bits 18 and up (HIW bits kept) and the priority in bits 7:0 (PW bits kept). A priority that is zero after masking is stored as 1, other bits read 0, and address 0 and sources above NSRC read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dom_ie_i | input | 1 | Domain-wide interrupt enable |
| src_en_i | input | NSRC | Per-source enable, bit s for source s |
| src_pend_i | input | NSRC | Per-source pending |
| src_lvlhi_i | input | NSRC | Source is in level-high mode |
| src_lvllo_i | input | NSRC | Source is in level-low mode |
| src_raw_i | input | NSRC | Raw source input level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of reg_rd_i |
| pend_clr_o | output | NSRC | One-cycle clear-pending strobe toward the source logic |
| hart_irq_o | output | NHART | Per-hart external interrupt line |

## Verification
The bench builds the block with 12 sources, 3 harts, 3 priority bits and a 2-bit target hart field. With these values a target can name hart 3, which does not exist, so the bench can show that such a source reaches no hart. With 3 priority bits, writes of 8 and 9 exercise both outcomes of the width mask: one value is cut to zero and then rewritten to 1, and the other is cut to 1. A threshold wider than 3 bits is trimmed on write. The small source count keeps equal-priority ties, level re-arming and non-enabled pending sources easy to set up and to read back through the top-interrupt and claim locations.

// File: rtl/hid_pkg.sv
package hid_pkg;
    localparam int TOPI_ID_LSB    = 16;
    localparam int TGT_HART_LSB   = 18;
    localparam int HART_BASE      = 'h100;
    localparam int HART_WIN_LOG2  = 5;
    localparam int TGT_IDX_W      = 6;

    localparam logic [4:0] OFF_DELIV = 5'h00;
    localparam logic [4:0] OFF_FORCE = 5'h04;
    localparam logic [4:0] OFF_THR   = 5'h08;
    localparam logic [4:0] OFF_TOPI  = 5'h18;
    localparam logic [4:0] OFF_CLAIM = 5'h1C;

    typedef logic [31:0] word_t;
endpackage

// File: rtl/hid_target_bank.sv
module hid_target_bank #(
    parameter int NSRC = 31,
    parameter int PW   = 3,
    parameter int HIW  = 2,
    parameter int IW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [IW-1:0]            idx_i,
    input  logic [HIW-1:0]           wd_hart_i,
    input  logic [PW-1:0]            wd_prio_i,
    output logic [NSRC:1][HIW-1:0]   hart_o,
    output logic [NSRC:1][PW-1:0]    prio_o
);
    typedef struct packed {
        logic [NSRC:1][HIW-1:0] hart;
        logic [NSRC:1][PW-1:0]  prio;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int s = 1; s <= NSRC; s++) begin
            if (wr_i && idx_i == IW'(s)) begin
                bank_d.hart[s] = wd_hart_i;
                bank_d.prio[s] = (wd_prio_i == '0) ? PW'(1) : wd_prio_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.hart <= '0;
            for (int s = 1; s <= NSRC; s++) begin
                bank_q.prio[s] <= PW'(1);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign hart_o = bank_q.hart;
    assign prio_o = bank_q.prio;

    for (genvar s = 1; s <= NSRC; s++) begin : g_chk
        // R10: a zero priority written to a record is stored as 1
        a_r10_zero_prio_one: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && idx_i == IW'(s) && wd_prio_i == '0) |=> (prio_o[s] == PW'(1)));
    end
endmodule

// File: rtl/hid_best_pick.sv
module hid_best_pick
    import hid_pkg::*;
#(
    parameter int NSRC    = 31,
    parameter int PW      = 3,
    parameter int HIW     = 2,
    parameter int SIW     = 5,
    parameter int HART_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC:1]          cand_i,
    input  logic [NSRC:1][HIW-1:0] hart_i,
    input  logic [NSRC:1][PW-1:0]  prio_i,
    input  logic [PW-1:0]          thr_i,
    output word_t                  topi_o
);
    logic            best_ok;
    logic [PW-1:0]   best_p;
    logic [SIW-1:0]  best_id;

    always_comb begin
        best_ok = 1'b0;
        best_p  = '1;
        best_id = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (cand_i[s] && hart_i[s] == HIW'(HART_ID) &&
                (thr_i == '0 || prio_i[s] < thr_i) &&
                (!best_ok || prio_i[s] < best_p)) begin
                best_ok = 1'b1;
                best_p  = prio_i[s];
                best_id = SIW'(s);
            end
        end
        topi_o = '0;
        if (best_ok) begin
            topi_o[TOPI_ID_LSB +: SIW] = best_id;
            topi_o[PW-1:0]             = best_p;
        end
    end

    // R4: a nonzero threshold only lets strictly smaller priorities through
    a_r4_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (topi_o != '0 && thr_i != '0) |-> (topi_o[PW-1:0] < thr_i));
    // R2: a reported source is enabled, pending and aimed at this hart
    a_r2_real_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        (topi_o != '0) |-> (cand_i[topi_o[TOPI_ID_LSB +: SIW]] &&
                            hart_i[topi_o[TOPI_ID_LSB +: SIW]] == HIW'(HART_ID)));
endmodule

// File: rtl/hid_hart_ctl.sv
module hid_hart_ctl
    import hid_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ie_i,
    input  logic          wr_deliv_i,
    input  logic          wr_force_i,
    input  logic          wr_thr_i,
    input  logic          wd_bit_i,
    input  logic [PW-1:0] wd_thr_i,
    input  logic          claim_i,
    input  word_t         topi_i,
    output logic          deliv_o,
    output logic          frc_o,
    output logic [PW-1:0] thr_o,
    output word_t         topi_o,
    output logic          irq_o
);
    typedef struct packed {
        logic          deliv;
        logic          frc;
        logic [PW-1:0] thr;
        word_t         topi;
    } hst_t;

    hst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.topi = topi_i;
        if (wr_deliv_i) st_d.deliv = wd_bit_i;
        if (wr_force_i) st_d.frc   = wd_bit_i;
        if (wr_thr_i)   st_d.thr   = wd_thr_i;
        if (claim_i && st_q.topi == '0) st_d.frc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign deliv_o = st_q.deliv;
    assign frc_o   = st_q.frc;
    assign thr_o   = st_q.thr;
    assign topi_o  = st_q.topi;
    assign irq_o   = ie_i & st_q.deliv & (st_q.frc | (st_q.topi != '0));

    // R8: an empty claim leaves the force bit cleared
    a_r8_empty_claim_drops_force: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && topi_o == '0 && !wr_force_i) |=> !frc_o);
    // R6: the line never rises without domain and delivery enables
    a_r6_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie_i && deliv_o));
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
    import hid_pkg::*;
#(
    parameter int NSRC  = 31,
    parameter int NHART = 4,
    parameter int PW    = 3,
    parameter int HIW   = 2,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dom_ie_i,
    input  logic [NSRC:1]     src_en_i,
    input  logic [NSRC:1]     src_pend_i,
    input  logic [NSRC:1]     src_lvlhi_i,
    input  logic [NSRC:1]     src_lvllo_i,
    input  logic [NSRC:1]     src_raw_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NSRC:1]     pend_clr_o,
    output logic [NHART-1:0]  hart_irq_o
);
    localparam int SIW = $clog2(NSRC + 1);

    logic [TGT_IDX_W-1:0]   tgt_idx;
    logic                   tgt_hit;
    logic [AW-1:0]          hart_rel;
    logic [AW-1:0]          hart_idx;
    logic                   hart_hit;
    logic [4:0]             off;
    logic                   wdata_unused;

    logic [NSRC:1][HIW-1:0] tgt_hart;
    logic [NSRC:1][PW-1:0]  tgt_prio;
    logic [NSRC:1]          cand;
    logic [NSRC:1]          rearm;

    logic [NHART-1:0]       wr_deliv, wr_force, wr_thr, claim;
    logic [NHART-1:0]       deliv, frc;
    logic [NHART-1:0][PW-1:0] thr;
    word_t                  topi_c [NHART];
    word_t                  topi_q [NHART];

    assign wdata_unused = ^reg_wdata_i;

    assign tgt_idx  = reg_addr_i[2 +: TGT_IDX_W];
    assign tgt_hit  = (reg_addr_i < AW'(HART_BASE)) && (reg_addr_i[1:0] == 2'b00) &&
                      (tgt_idx != '0) && (tgt_idx <= TGT_IDX_W'(NSRC));
    assign hart_rel = reg_addr_i - AW'(HART_BASE);
    assign hart_idx = hart_rel >> HART_WIN_LOG2;
    assign hart_hit = (reg_addr_i >= AW'(HART_BASE)) && (hart_idx < AW'(NHART)) &&
                      (reg_addr_i[1:0] == 2'b00);
    assign off      = reg_addr_i[4:0];

    assign cand  = src_en_i & src_pend_i;
    assign rearm = (src_lvlhi_i & src_raw_i) | (src_lvllo_i & ~src_raw_i);

    hid_target_bank #(
        .NSRC (NSRC),
        .PW   (PW),
        .HIW  (HIW),
        .IW   (TGT_IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i && tgt_hit),
        .idx_i     (tgt_idx),
        .wd_hart_i (reg_wdata_i[TGT_HART_LSB +: HIW]),
        .wd_prio_i (reg_wdata_i[PW-1:0]),
        .hart_o    (tgt_hart),
        .prio_o    (tgt_prio)
    );

    for (genvar h = 0; h < NHART; h++) begin : g_hart
        logic sel;
        assign sel         = hart_hit && (hart_idx == AW'(h));
        assign wr_deliv[h] = reg_wr_i && sel && (off == OFF_DELIV);
        assign wr_force[h] = reg_wr_i && sel && (off == OFF_FORCE);
        assign wr_thr[h]   = reg_wr_i && sel && (off == OFF_THR);
        assign claim[h]    = reg_rd_i && sel && (off == OFF_CLAIM);

        hid_best_pick #(
            .NSRC    (NSRC),
            .PW      (PW),
            .HIW     (HIW),
            .SIW     (SIW),
            .HART_ID (h)
        ) u_pick (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (cand),
            .hart_i (tgt_hart),
            .prio_i (tgt_prio),
            .thr_i  (thr[h]),
            .topi_o (topi_c[h])
        );

        hid_hart_ctl #(
            .PW (PW)
        ) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .ie_i       (dom_ie_i),
            .wr_deliv_i (wr_deliv[h]),
            .wr_force_i (wr_force[h]),
            .wr_thr_i   (wr_thr[h]),
            .wd_bit_i   (reg_wdata_i[0]),
            .wd_thr_i   (reg_wdata_i[PW-1:0]),
            .claim_i    (claim[h]),
            .topi_i     (topi_c[h]),
            .deliv_o    (deliv[h]),
            .frc_o      (frc[h]),
            .thr_o      (thr[h]),
            .topi_o     (topi_q[h]),
            .irq_o      (hart_irq_o[h])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (tgt_hit) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (tgt_idx == TGT_IDX_W'(s)) begin
                    reg_rdata_o[TGT_HART_LSB +: HIW] = tgt_hart[s];
                    reg_rdata_o[PW-1:0]              = tgt_prio[s];
                end
            end
        end else if (hart_hit) begin
            for (int h = 0; h < NHART; h++) begin
                if (hart_idx == AW'(h)) begin
                    case (off)
                        OFF_DELIV: reg_rdata_o[0]      = deliv[h];
                        OFF_FORCE: reg_rdata_o[0]      = frc[h];
                        OFF_THR:   reg_rdata_o[PW-1:0] = thr[h];
                        OFF_TOPI,
                        OFF_CLAIM: reg_rdata_o         = topi_q[h];
                        default:   reg_rdata_o         = '0;
                    endcase
                end
            end
        end
    end

    always_comb begin
        pend_clr_o = '0;
        for (int h = 0; h < NHART; h++) begin
            for (int s = 1; s <= NSRC; s++) begin
                if (claim[h] && topi_q[h][TOPI_ID_LSB +: SIW] == SIW'(s) && !rearm[s]) begin
                    pend_clr_o[s] = 1'b1;
                end
            end
        end
    end

    // R7: at most one source is released per claim
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr_o));
    // R7: a clear pulse only accompanies a read
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr_o != '0) |-> reg_rd_i);
    for (genvar s = 1; s <= NSRC; s++) begin : g_rearm_chk
        // R7: an active level source is never released
        a_r7_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
            rearm[s] |-> !pend_clr_o[s]);
    end
endmodule

// File: tb/sim_hart_irq_deliver.sv
module sim_hart_irq_deliver;
    localparam int NS = 12;
    localparam int NH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dom_ie = 1'b0;
    logic [NS:1]     en = '0, pend = '0, lvlhi = '0, lvllo = '0, raw = '0;
    logic            reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NS:1]     pend_clr;
    logic [NH-1:0]   hart_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic [NS:1] clr;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    hart_irq_deliver #(
        .NSRC (NS), .NHART (NH), .PW (3), .HIW (2), .AW (10)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dom_ie_i    (dom_ie),
        .src_en_i    (en),
        .src_pend_i  (pend),
        .src_lvlhi_i (lvlhi),
        .src_lvllo_i (lvllo),
        .src_raw_i   (raw),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .pend_clr_o  (pend_clr),
        .hart_irq_o  (hart_irq)
    );

    function automatic logic [NS:1] oh(int s);
        logic [NS:1] v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input logic [NS:1] clr,
                      input string tag);
        item_t it;
        @(negedge clk);
        it.d = exp; it.clr = clr; it.tag = tag;
        sb.push_back(it);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_line(input logic [NH-1:0] exp, input string tag);
        @(negedge clk);
        #8;
        total++;
        if (hart_irq !== exp) begin
            fails++;
            $display("FAIL %s: hart_irq=%b expected=%b", tag, hart_irq, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #8;
            if (reg_rd) begin
                total++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard: read with no expectation, rdata=%h expected=none", reg_rdata);
                end else begin
                    it = sb.pop_front();
                    if (reg_rdata !== it.d || pend_clr !== it.clr) begin
                        fails++;
                        $display("FAIL %s: rdata=%h clr=%b expected rdata=%h clr=%b",
                                 it.tag, reg_rdata, pend_clr, it.d, it.clr);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'd20,  32'h1, '0, "R1 target reset prio 1 hart 0");
        rd(10'h100, 32'h0, '0, "R1 delivery reset");
        rd(10'h108, 32'h0, '0, "R1 threshold reset");
        rd(10'h118, 32'h0, '0, "R1 top word reset");
        chk_line(3'b000, "R1 lines low");

        // R10 target records
        wr(10'd12, 32'h0000_0004);
        wr(10'd20, 32'h0000_0002);
        wr(10'd28, 32'h0000_0002);
        wr(10'd8,  (32'd1 << 18) | 32'd8);
        wr(10'd36, (32'd3 << 18) | 32'd1);
        wr(10'd40, 32'h0000_0009);
        wr(10'd16, 32'hFFFF_FFFF);
        rd(10'd8,  32'h0004_0001, '0, "R10 masked-zero prio becomes 1");
        rd(10'd40, 32'h0000_0001, '0, "R10 prio masked to width");
        rd(10'd16, 32'h000C_0007, '0, "R10 extra bits dropped");
        rd(10'd0,  32'h0, '0, "R10 address 0 reads 0");
        rd(10'd52, 32'h0, '0, "R10 source beyond NSRC reads 0");

        // R2 / R5 single candidate
        @(negedge clk);
        en = oh(2) | oh(3) | oh(5) | oh(7) | oh(9);
        pend = oh(3);
        rd(10'h118, 32'h0003_0004, '0, "R5 top word id/prio layout");
        rd(10'h138, 32'h0, '0, "R2 other hart sees nothing");

        // R3 priority and tie
        @(negedge clk);
        pend = pend | oh(5) | oh(7);
        rd(10'h118, 32'h0005_0002, '0, "R3 lowest prio, lowest source on tie");

        // R2 non-enabled pending and absent hart
        @(negedge clk);
        pend = pend | oh(10) | oh(9);
        rd(10'h118, 32'h0005_0002, '0, "R2 pending but disabled source ignored");
        rd(10'h158, 32'h0, '0, "R2 target hart 3 absent reaches no hart");
        rd(10'h178, 32'h0, '0, "R9 window beyond NHART reads 0");

        // R4 threshold
        wr(10'h108, 32'd2);
        rd(10'h118, 32'h0, '0, "R4 prio equal to threshold filtered");
        wr(10'h108, 32'hF);
        rd(10'h108, 32'h7, '0, "R9 threshold masked to width");
        rd(10'h118, 32'h0005_0002, '0, "R4 prio below threshold passes");
        wr(10'h108, 32'd0);

        // R6 line
        wr(10'h100, 32'd3);
        rd(10'h100, 32'h1, '0, "R9 delivery keeps bit 0");
        chk_line(3'b000, "R6 domain enable low");
        @(negedge clk);
        dom_ie = 1'b1;
        chk_line(3'b001, "R6 line with candidate");
        wr(10'h120, 32'd1);
        chk_line(3'b001, "R6 delivery on but no candidate");
        wr(10'h124, 32'hFF);
        rd(10'h124, 32'h1, '0, "R9 force keeps bit 0");
        chk_line(3'b011, "R6 force raises line");

        // R8 empty claim
        rd(10'h13C, 32'h0, '0, "R8 empty claim returns 0");
        rd(10'h124, 32'h0, '0, "R8 force cleared by empty claim");
        chk_line(3'b001, "R8 line drops with force");

        // R7 claims
        rd(10'h11C, 32'h0005_0002, oh(5), "R7 edge claim clears pending");
        @(negedge clk);
        pend[5] = 1'b0;
        rd(10'h118, 32'h0007_0002, '0, "R7 next source after release");
        @(negedge clk);
        lvlhi[7] = 1'b1; raw[7] = 1'b1;
        rd(10'h11C, 32'h0007_0002, '0, "R7 level-high active re-armed");
        @(negedge clk);
        lvlhi[7] = 1'b0; lvllo[7] = 1'b1;
        rd(10'h11C, 32'h0007_0002, oh(7), "R7 level-low inactive released");
        @(negedge clk);
        pend[7] = 1'b0;
        lvllo[3] = 1'b1; raw[3] = 1'b0;
        rd(10'h11C, 32'h0003_0004, '0, "R7 level-low active re-armed");
        rd(10'h10C, 32'h0, '0, "R9 unused offset reads 0");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule